// File: doc/BRIEF.md
# Capture/Compare/PWM Timer Channel

This block is a single channel of a general-purpose timer. It sits beside a shared counter that it does not own. The counter supplies three things: its current count, a strobe for each cycle in which the count advances, and a strobe for the cycle in which the count wraps at its modulo value. Software picks the channel's behaviour through one control byte, which holds a compare-mode bit and a two-bit level field:

- In capture mode, a selected edge on the channel input latches the count into the 16-bit channel value and raises the channel flag.
- In compare mode, a count equal to the channel value applies a pin action (toggle, clear or set) and raises the flag.
- With the level field at zero, the channel leaves its pin undriven.

An unbuffered PWM needs one more option: the pin also toggles on every counter wrap, and a compare action returns it to the opposite level. A max-duty bit holds the PWM output at its full-on level. That bit changes the output only at the next wrap. A timer reset presets the pin to a known level while the channel is in compare mode. The interrupt request is the flag gated by an enable bit. Software clears the flag with a two-step sequence: it reads the control byte and then writes the flag bit as 0.

The reset input is asynchronous and active low. It is expected to be released synchronously to the clock by the reset logic around the block.

Top module: `cc_timer_channel`

## Requirements
- R1: After reset the control byte reads 0x00, the channel value reads 0, and `pin_out`, `pin_oe` and `irq` are all 0.
- R2: The control byte has this layout:
  - bit 7: flag.
  - bit 6: interrupt enable.
  - bit 5: compare mode.
  - bits 4:3: level field.
  - bit 2: toggle-on-wrap.
  - bit 1: max duty.
  - bit 0: reads 0.

  With the level field at 00, `pin_oe` is 0. In compare mode a match still sets the flag.
- R3: In capture mode (bit 5 = 0), the level field selects the capturing edge:
  - 01 captures on a rising edge only.
  - 10 captures on a falling edge only.
  - 11 captures on either edge.

  A capture sets the flag and latches the count that is present two clock cycles after the input changes.
- R4: In compare mode, a match occurs in a cycle where `cnt_tick` is 1 and `cnt_val` equals the channel value. The match sets the flag. The level field then decides the pin action: 01 toggles the pin, 10 drives it to 0, and 11 drives it to 1. `pin_out` shows the new level from the following cycle.
- R5: The flag stays set until the clearing sequence completes:
  1. A read of the control byte while the flag is 1 arms the clear.
  2. The next write with bit 7 = 0 then clears the flag.

  A write that was not preceded by such a read leaves the flag set. A new event in the same cycle as the clearing write keeps the flag set.
- R6: With toggle-on-wrap set in compare mode and a non-zero level field, the pin toggles in each cycle where `cnt_ovf` is 1. In capture mode the bit has no effect on the pin.
- R7: When a match and a wrap occur in the same cycle with toggle-on-wrap set, the pin toggles and the compare action is dropped.
- R8: A channel value above the counter's modulo value never matches: the flag stays clear and the pin does not change.
- R9: The max-duty bit takes effect only at the next wrap, in either direction. While it is active in compare mode with a non-zero level field, `pin_out` is held high for level 01 or 10 and low for level 11.
- R10: A `tmr_rst` pulse in compare mode sets the pin as follows: level 10 drives it low, level 11 drives it high, and level 01 leaves it unchanged.
- R11: `irq` is 1 exactly when the flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Shared counter value |
| cnt_tick | input | 1 | Counter advances from its current value this cycle |
| cnt_ovf | input | 1 | Counter wraps to zero this cycle |
| tmr_rst | input | 1 | Timer reset pulse (pin preset) |
| csr_wr | input | 1 | Write strobe for the control byte |
| csr_rd | input | 1 | Read strobe for the control byte (arms flag clear) |
| csr_wdata | input | 8 | Control byte write data |
| csr_rdata | output | 8 | Control byte read data |
| val_wr | input | 1 | Write strobe for the channel value |
| val_wdata | input | 16 | Channel value write data |
| val_rdata | output | 16 | Channel value (capture result or compare value) |
| cap_in | input | 1 | Asynchronous capture input |
| pin_out | output | 1 | Channel pin level |
| pin_oe | output | 1 | Channel drives its pin |
| irq | output | 1 | Interrupt request |

## Verification
The situation hardest to reach from the ports is a compare match that lands on the very cycle the counter wraps. In that cycle the PWM toggle and the clear action compete for the pin. The stimulus sets the channel value equal to the bench's modulo value. Every period then produces the collision, and the bench checks that the pin simply alternates each period. The deferral of max duty is also awkward to reach, because it can only be seen across a period boundary. The bench changes the bit in mid-period and samples the pin both before and after the next wrap, in both directions.

// File: rtl/cc_chan_pkg.sv
package cc_chan_pkg;

  localparam int unsigned CSR_W      = 8;
  localparam int unsigned BIT_FLAG   = 7;
  localparam int unsigned BIT_IE     = 6;
  localparam int unsigned BIT_CMP    = 5;
  localparam int unsigned BIT_LVL_HI = 4;
  localparam int unsigned BIT_LVL_LO = 3;
  localparam int unsigned BIT_TOV    = 2;
  localparam int unsigned BIT_MAX    = 1;

  typedef enum logic [1:0] {
    LVL_OFF = 2'b00,
    LVL_A   = 2'b01,
    LVL_B   = 2'b10,
    LVL_C   = 2'b11
  } cc_lvl_e;

  typedef struct packed {
    logic    ie;
    logic    cmp;
    cc_lvl_e lvl;
    logic    tov;
    logic    max;
  } cc_ctrl_t;

endpackage

// File: rtl/cc_sync_edge.sv
module cc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic sel_rise,
  input  logic sel_fall,
  output logic evt
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign sync_d[g] = din;
    end else begin : g_next
      assign sync_d[g] = sync_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q[g] <= 1'b0;
      end else begin
        sync_q[g] <= sync_d[g];
      end
    end
  end

  assign prev_d = sync_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  always_comb begin
    evt = 1'b0;
    if (sel_rise && sync_q[LAST] && !prev_q) begin
      evt = 1'b1;
    end
    if (sel_fall && !sync_q[LAST] && prev_q) begin
      evt = 1'b1;
    end
  end

endmodule

// File: rtl/cc_csr.sv
module cc_csr
  import cc_chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [CSR_W-1:0] wdata,
  input  logic             set_evt,
  output cc_ctrl_t         ctrl,
  output logic             flag,
  output logic [CSR_W-1:0] rdata
);

  cc_ctrl_t ctrl_q, ctrl_d;
  logic     flag_q, flag_d;
  logic     arm_q, arm_d;
  logic     clr_req;

  assign clr_req = wr && arm_q && !wdata[BIT_FLAG];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr) begin
      ctrl_d.ie  = wdata[BIT_IE];
      ctrl_d.cmp = wdata[BIT_CMP];
      ctrl_d.lvl = cc_lvl_e'(wdata[BIT_LVL_HI:BIT_LVL_LO]);
      ctrl_d.tov = wdata[BIT_TOV];
      ctrl_d.max = wdata[BIT_MAX];
    end
  end

  always_comb begin
    arm_d = arm_q;
    if (wr) begin
      arm_d = 1'b0;
    end else if (rd && flag_q) begin
      arm_d = 1'b1;
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (set_evt) begin
      flag_d = 1'b1;
    end else if (clr_req) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign ctrl = ctrl_q;
  assign flag = flag_q;

  always_comb begin
    rdata              = '0;
    rdata[BIT_FLAG]    = flag_q;
    rdata[BIT_IE]      = ctrl_q.ie;
    rdata[BIT_CMP]     = ctrl_q.cmp;
    rdata[BIT_LVL_HI]  = ctrl_q.lvl[1];
    rdata[BIT_LVL_LO]  = ctrl_q.lvl[0];
    rdata[BIT_TOV]     = ctrl_q.tov;
    rdata[BIT_MAX]     = ctrl_q.max;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr && arm_q)) |=> flag_q); // R5

  AST_FLAG_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q); // R4

endmodule

// File: rtl/cc_pin_ctl.sv
module cc_pin_ctl
  import cc_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             cnt_tick,
  input  logic             cnt_ovf,
  input  logic             tmr_rst,
  input  cc_ctrl_t         ctrl,
  output logic             match,
  output logic             pin_out,
  output logic             pin_oe
);

  logic pin_q, pin_d;
  logic max_q, max_d;
  logic active;
  logic force_lvl;

  assign active = ctrl.cmp && (ctrl.lvl != LVL_OFF);
  assign match  = ctrl.cmp && cnt_tick && (cnt_val == cmp_val);

  always_comb begin
    max_d = max_q;
    if (tmr_rst || cnt_ovf) begin
      max_d = ctrl.max;
    end
  end

  always_comb begin
    pin_d = pin_q;
    if (tmr_rst) begin
      if (ctrl.cmp) begin
        case (ctrl.lvl)
          LVL_B:   pin_d = 1'b0;
          LVL_C:   pin_d = 1'b1;
          default: pin_d = pin_q;
        endcase
      end
    end else if (active) begin
      if (cnt_ovf && ctrl.tov) begin
        pin_d = ~pin_q;
      end else if (match) begin
        case (ctrl.lvl)
          LVL_A:   pin_d = ~pin_q;
          LVL_B:   pin_d = 1'b0;
          LVL_C:   pin_d = 1'b1;
          default: pin_d = pin_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      max_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
      max_q <= max_d;
    end
  end

  assign force_lvl = (ctrl.lvl != LVL_C);

  always_comb begin
    pin_out = pin_q;
    if (max_q && active) begin
      pin_out = force_lvl;
    end
  end

  assign pin_oe = active;

  AST_CAPTURE_HOLDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.cmp && !tmr_rst) |=> $stable(pin_q)); // R6

  AST_WRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_rst && active && ctrl.tov && cnt_ovf && match) |=> (pin_q != $past(pin_q))); // R7

  AST_MAX_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_ovf && !tmr_rst) |=> $stable(max_q)); // R9

  AST_PRESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_rst && ctrl.cmp && ctrl.lvl == LVL_B) |=> !pin_q); // R10

endmodule

// File: rtl/cc_timer_channel.sv
module cc_timer_channel
  import cc_chan_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_tick,
  input  logic             cnt_ovf,
  input  logic             tmr_rst,
  input  logic             csr_wr,
  input  logic             csr_rd,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] val_wdata,
  output logic [CNT_W-1:0] val_rdata,
  input  logic             cap_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             irq
);

  cc_ctrl_t         ctrl;
  logic             flag;
  logic             cap_evt;
  logic             cmp_match;
  logic             set_evt;
  logic             sel_rise;
  logic             sel_fall;
  logic [CNT_W-1:0] val_q, val_d;

  assign sel_rise = !ctrl.cmp && ctrl.lvl[0];
  assign sel_fall = !ctrl.cmp && ctrl.lvl[1];

  cc_sync_edge #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (cap_in),
    .sel_rise (sel_rise),
    .sel_fall (sel_fall),
    .evt      (cap_evt)
  );

  assign set_evt = cap_evt || cmp_match;

  cc_csr u_csr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (csr_wr),
    .rd      (csr_rd),
    .wdata   (csr_wdata),
    .set_evt (set_evt),
    .ctrl    (ctrl),
    .flag    (flag),
    .rdata   (csr_rdata)
  );

  always_comb begin
    val_d = val_q;
    if (cap_evt) begin
      val_d = cnt_val;
    end else if (val_wr) begin
      val_d = val_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else begin
      val_q <= val_d;
    end
  end

  assign val_rdata = val_q;

  cc_pin_ctl #(
    .CNT_W (CNT_W)
  ) u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_val  (cnt_val),
    .cmp_val  (val_q),
    .cnt_tick (cnt_tick),
    .cnt_ovf  (cnt_ovf),
    .tmr_rst  (tmr_rst),
    .ctrl     (ctrl),
    .match    (cmp_match),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  assign irq = flag && ctrl.ie;

  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (val_q == $past(cnt_val))); // R3

endmodule

// File: tb/cc_timer_channel_tb_top.sv
module cc_timer_channel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic [15:0] mod = 16'hFFFF;
  logic        run = 1'b0;
  logic        tmr_rst = 1'b0;
  logic        csr_wr = 1'b0, csr_rd = 1'b0;
  logic [7:0]  csr_wdata = '0;
  logic [7:0]  csr_rdata;
  logic        val_wr = 1'b0;
  logic [15:0] val_wdata = '0;
  logic [15:0] val_rdata;
  logic        cap_in = 1'b0;
  logic        pin_out, pin_oe, irq;
  logic        tick, ovf;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  assign tick = run && !tmr_rst;
  assign ovf  = tick && (cnt == mod);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (tmr_rst)  cnt <= '0;
    else if (tick)     cnt <= (cnt == mod) ? 16'd0 : cnt + 16'd1;
  end

  cc_timer_channel dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt), .cnt_tick(tick), .cnt_ovf(ovf),
    .tmr_rst(tmr_rst), .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .val_wr(val_wr), .val_wdata(val_wdata),
    .val_rdata(val_rdata), .cap_in(cap_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  // Each entry: level[4:3], input from[2], input to[1], capture expected[0]
  localparam logic [4:0] CAP_VEC [6] = '{
    5'b01_01_1, 5'b01_10_0, 5'b10_01_0, 5'b10_10_1, 5'b11_01_1, 5'b11_10_1
  };

  function automatic logic [7:0] mk(logic ie, logic cmp, logic [1:0] lvl, logic tov, logic mx);
    return {1'b0, ie, cmp, lvl, tov, mx, 1'b0};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic csr_write(logic [7:0] v);
    @(negedge clk); csr_wr = 1'b1; csr_wdata = v;
    @(negedge clk); csr_wr = 1'b0;
  endtask

  task automatic csr_read();
    @(negedge clk); csr_rd = 1'b1;
    @(negedge clk); csr_rd = 1'b0;
  endtask

  task automatic val_write(logic [15:0] v);
    @(negedge clk); val_wr = 1'b1; val_wdata = v;
    @(negedge clk); val_wr = 1'b0;
  endtask

  task automatic clear_flag(logic [7:0] v);
    csr_read();
    csr_write(v);
  endtask

  task automatic pulse_trst();
    @(negedge clk); tmr_rst = 1'b1;
    @(negedge clk); tmr_rst = 1'b0;
  endtask

  task automatic wait_cnt(logic [15:0] n);
    do @(negedge clk); while (cnt != n);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] c0;
    logic        p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 csr", {8'h0, csr_rdata}, 16'h0);
    chk("R1 val", val_rdata, 16'h0);
    chk("R1 pins", {13'h0, pin_out, pin_oe, irq}, 16'h0);

    // R3 capture edge table
    run = 1'b1;
    mod = 16'hFFFF;
    pulse_trst();
    for (int i = 0; i < 6; i++) begin
      cap_in = CAP_VEC[i][2];
      repeat (5) @(negedge clk);
      csr_write(mk(0, 0, CAP_VEC[i][4:3], 0, 0));
      clear_flag(mk(0, 0, CAP_VEC[i][4:3], 0, 0));
      c0 = cnt;
      cap_in = CAP_VEC[i][1];
      repeat (4) @(negedge clk);
      chk($sformatf("R3 flag vec%0d", i), {15'h0, csr_rdata[7]}, {15'h0, CAP_VEC[i][0]});
      if (CAP_VEC[i][0]) chk($sformatf("R3 value vec%0d", i), val_rdata, c0 + 16'd2);
    end

    // R4 toggle, R11 irq gating, R5 clear sequence
    mod = 16'd99;
    csr_write(mk(0, 1, 2'b01, 0, 0));
    val_write(16'd20);
    pulse_trst();
    clear_flag(mk(0, 1, 2'b01, 0, 0));
    wait_cnt(20);
    chk("R4 toggle before match", {15'h0, pin_out}, 16'h0);
    wait_cnt(21);
    chk("R4 toggle after match", {15'h0, pin_out}, 16'h1);
    chk("R4 flag on match", {15'h0, csr_rdata[7]}, 16'h1);
    chk("R11 irq masked", {15'h0, irq}, 16'h0);
    csr_write(mk(1, 1, 2'b01, 0, 0));
    chk("R5 flag kept without read", {15'h0, csr_rdata[7]}, 16'h1);
    chk("R11 irq enabled", {15'h0, irq}, 16'h1);
    clear_flag(mk(1, 1, 2'b01, 0, 0));
    chk("R5 flag cleared", {15'h0, csr_rdata[7]}, 16'h0);
    chk("R11 irq after clear", {15'h0, irq}, 16'h0);

    // R10 preset and R4 clear/set actions
    csr_write(mk(0, 1, 2'b11, 0, 0));
    pulse_trst();
    chk("R10 preset high", {15'h0, pin_out}, 16'h1);
    csr_write(mk(0, 1, 2'b10, 0, 0));
    wait_cnt(21);
    chk("R4 clear action", {15'h0, pin_out}, 16'h0);
    pulse_trst();
    chk("R10 preset low", {15'h0, pin_out}, 16'h0);
    csr_write(mk(0, 1, 2'b11, 0, 0));
    wait_cnt(21);
    chk("R4 set action", {15'h0, pin_out}, 16'h1);
    csr_write(mk(0, 1, 2'b01, 0, 0));
    pulse_trst();
    chk("R10 toggle keeps pin", {15'h0, pin_out}, 16'h1);

    // R6 unbuffered PWM
    csr_write(mk(0, 1, 2'b10, 1, 0));
    val_write(16'd30);
    pulse_trst();
    wait_cnt(50);
    chk("R6 pwm low first period", {15'h0, pin_out}, 16'h0);
    wait_cnt(5);
    chk("R6 pwm high after wrap", {15'h0, pin_out}, 16'h1);
    chk("R6 pwm driven", {15'h0, pin_oe}, 16'h1);
    wait_cnt(31);
    chk("R6 pwm low after match", {15'h0, pin_out}, 16'h0);

    // R9 max duty, set and cleared mid-period
    csr_write(mk(0, 1, 2'b10, 1, 1));
    wait_cnt(60);
    chk("R9 max deferred on", {15'h0, pin_out}, 16'h0);
    wait_cnt(40);
    chk("R9 max active", {15'h0, pin_out}, 16'h1);
    csr_write(mk(0, 1, 2'b10, 1, 0));
    wait_cnt(60);
    chk("R9 max deferred off", {15'h0, pin_out}, 16'h1);
    wait_cnt(40);
    chk("R9 max released", {15'h0, pin_out}, 16'h0);

    // R7 match on wrap cycle
    val_write(16'd99);
    pulse_trst();
    wait_cnt(50);
    chk("R7 first period", {15'h0, pin_out}, 16'h0);
    wait_cnt(5);
    chk("R7 wrap toggle wins", {15'h0, pin_out}, 16'h1);
    wait_cnt(50);
    wait_cnt(5);
    chk("R7 second wrap", {15'h0, pin_out}, 16'h0);

    // R8 compare value above modulo
    csr_write(mk(0, 1, 2'b01, 0, 0));
    val_write(16'd150);
    clear_flag(mk(0, 1, 2'b01, 0, 0));
    p = pin_out;
    wait_cnt(50); wait_cnt(50); wait_cnt(50);
    chk("R8 no flag", {15'h0, csr_rdata[7]}, 16'h0);
    chk("R8 pin unchanged", {15'h0, pin_out}, {15'h0, p});

    // R6 toggle-on-wrap ignored in capture mode
    csr_write(mk(0, 0, 2'b01, 1, 0));
    p = pin_out;
    wait_cnt(50); wait_cnt(50);
    chk("R6 capture pin stable", {15'h0, pin_out}, {15'h0, p});
    chk("R6 capture not driven", {15'h0, pin_oe}, 16'h0);

    // R2 level 00: no drive, flag and irq still produced
    csr_write(mk(1, 1, 2'b00, 0, 0));
    val_write(16'd20);
    clear_flag(mk(1, 1, 2'b00, 0, 0));
    chk("R2 not driven", {15'h0, pin_oe}, 16'h0);
    wait_cnt(21);
    chk("R2 flag set", {15'h0, csr_rdata[7]}, 16'h1);
    chk("R2 irq raised", {15'h0, irq}, 16'h1);

    summary();
  end

endmodule